// File: doc/BRIEF.md
# Supply Controller Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus (I2C) target that holds the control and status registers of a supply controller. It answers one of two 7-bit device addresses, picked by a strap input. A master first sends a register pointer. It then either writes a run of consecutive registers, or, after a STOP and a new START with the read bit set, reads a run of consecutive registers back. The pointer moves forward by one after every data byte.

The bus lines pass through a synchroniser clocked by the system clock before any edge is detected. The target drives SDA only by pulling it low, through an output-enable pin. Two read-only status bytes at the bottom of the map show live fault flags from the protection logic. Each time the flag byte has been fully shifted out, the block sends a one-cycle strobe, so that the fault block can clear its latched flags. The writable control bytes are brought out as individual field outputs. An undervoltage input makes the block ignore the bus and clears every control byte. A clear input from the protection controller zeroes the output-voltage select field.

Top module: `psc_i2c_regs`

## Requirements
- R1: The device address is 7'b0001000 when `addr_sel_i` is low and 7'b0001001 when it is high. It is carried in bits 7:1 of the first byte after START, and bit 0 of that byte is 1 for read and 0 for write. A first byte with any other address gets no ACK.
- R2: In a write, the byte after the address is the register pointer. Each following data byte is stored at the pointer, and the pointer then goes up by one.
- R3: After a pointer write and a STOP, a START with the read bit set makes the block send the register at the pointer. It sends the next register each time the master answers with ACK low, and stops driving after the master leaves ACK high.
- R4: The block pulls SDA low during the ninth clock of every byte it accepts, sends data MSB first, and changes its SDA drive only while SCL is low.
- R5: Register 0x0 reads as {supply-low flag, over-temperature flag, 5'b0, overload flag}, from bit 7 down to bit 0. Register 0x1 reads as 0x00.
- R6: Registers 0x2 to 0x5 read back the last value written. The outputs are: `vsel_o` = 0x2[3:0], `tone_en_o` = 0x3[0], `tone_ext_o` = 0x3[2], `plim_off_o` = 0x4[2], `ovl_hold_o` = 0x5[3] and `thm_hold_o` = 0x5[6].
- R7: Writes to 0x0, 0x1 or any pointer above 0x5 are acknowledged but change nothing. Reads of a pointer above 0x5 return 0x00.
- R8: While `uv_i` is high, no byte is acknowledged and all control registers are zero.
- R9: After reset, all control registers and all outputs are zero.
- R10: `stat_rd_o` pulses high for exactly one clock after each byte read from register 0x0 has been fully shifted out, and at no other time.
- R11: A high `vsel_clr_i` forces register 0x2 bits 3:0 to zero and leaves bits 7:4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| uv_i | input | 1 | Undervoltage: bus ignored, controls cleared |
| addr_sel_i | input | 1 | Address strap, LSB of device address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | High pulls SDA low (open drain) |
| ovl_flag_i | input | 1 | Live overload flag |
| otp_flag_i | input | 1 | Live over-temperature flag |
| vlow_flag_i | input | 1 | Live supply-low flag |
| vsel_clr_i | input | 1 | Forces the voltage-select field to zero |
| vsel_o | output | 4 | Output voltage select |
| tone_en_o | output | 1 | Tone enable |
| tone_ext_o | output | 1 | External tone mode |
| plim_off_o | output | 1 | Pulsed current limit disabled |
| ovl_hold_o | output | 1 | No automatic restart after overload |
| thm_hold_o | output | 1 | No automatic restart after over-temperature |
| stat_rd_o | output | 1 | One-cycle strobe after flag byte read |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, device base address 0x08, an 8-bit pointer, and four control bytes starting at 0x2. With these values, pointer 0x6 is the first address past the map, so the discarded-write and zero-read paths can be reached in a single burst. The strap toggles between the two address variants. A reference model of the register map is kept in the bench, and every control output is compared with it on every clock while the bus is idle.

// File: rtl/psc_pkg.sv
package psc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_SKIP
   } bus_st_t;

   localparam int unsigned BYTE_W = 8;

   function automatic logic [BYTE_W-1:0] flag_byte(input logic ovl,
                                                   input logic otp,
                                                   input logic vlow);
      flag_byte = {vlow, otp, 5'b0, ovl};
   endfunction
endpackage

// File: rtl/psc_line_sync.sv
module psc_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          IDLE_HI = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE_HI}};
         prev_q  <= IDLE_HI;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/psc_bus_engine.sv
module psc_bus_engine
   import psc_pkg::*;
#(
   parameter logic [6:0]  DEV_BASE = 7'b0001000,
   parameter int unsigned PTR_W    = 8,
   parameter int unsigned FLAG_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uv,
   input  logic             strap,
   input  logic             scl_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_s,
   input  logic             sda_rise,
   input  logic             sda_fall,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] ptr,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_addr,
   output logic [7:0]       wr_data,
   output logic             sda_oe,
   output logic             stat_pulse
);
   localparam logic [PTR_W-1:0] FLAG_PTR = PTR_W'(FLAG_REG);
   localparam logic [3:0]       BITS     = 4'd8;

   bus_st_t    st;
   logic [3:0] cnt;
   logic [7:0] shreg;
   logic       rw;
   logic       have_ptr;
   logic       mack;
   logic [6:0] dev_addr;
   logic       start_det;
   logic       stop_det;

   assign dev_addr  = {DEV_BASE[6:1], DEV_BASE[0] | strap};
   assign start_det = scl_s & sda_fall;
   assign stop_det  = scl_s & sda_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         rw         <= 1'b0;
         have_ptr   <= 1'b0;
         mack       <= 1'b0;
         ptr        <= '0;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         sda_oe     <= 1'b0;
         stat_pulse <= 1'b0;
      end else if (uv) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         rw         <= 1'b0;
         have_ptr   <= 1'b0;
         mack       <= 1'b0;
         ptr        <= '0;
         wr_en      <= 1'b0;
         sda_oe     <= 1'b0;
         stat_pulse <= 1'b0;
      end else begin
         wr_en      <= 1'b0;
         stat_pulse <= 1'b0;
         if (start_det) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            have_ptr <= 1'b0;
            sda_oe   <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_RX: begin
                  if (scl_rise && cnt < BITS) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end
                  if (scl_fall && cnt == BITS) begin
                     if (st == ST_ADDR) begin
                        if (shreg[7:1] == dev_addr) begin
                           rw     <= shreg[0];
                           sda_oe <= 1'b1;
                           st     <= ST_ACK;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK;
                        if (!have_ptr) begin
                           ptr      <= shreg[PTR_W-1:0];
                           have_ptr <= 1'b1;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= shreg;
                           ptr     <= ptr + 1'b1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise && cnt < BITS)
                     cnt <= cnt + 4'd1;
                  if (scl_fall) begin
                     if (cnt == BITS) begin
                        sda_oe     <= 1'b0;
                        stat_pulse <= (ptr == FLAG_PTR);
                        ptr        <= ptr + 1'b1;
                        st         <= ST_MACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise)
                     mack <= ~sda_s;
                  if (scl_fall) begin
                     if (mack) begin
                        cnt    <= '0;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_UV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      uv |=> !sda_oe);  // R8
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_pulse |=> !stat_pulse);  // R10
   AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n || uv)
      (!$stable(sda_oe) && !$past(uv)) |-> !scl_s);  // R4
endmodule

// File: rtl/psc_regbank.sv
module psc_regbank
   import psc_pkg::*;
#(
   parameter int unsigned PTR_W     = 8,
   parameter int unsigned CTRL_BASE = 2,
   parameter int unsigned NUM_CTRL  = 4,
   parameter int unsigned FLAG_REG  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uv,
   input  logic             vsel_clr,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [PTR_W-1:0] rd_addr,
   output logic [7:0]       rd_data,
   input  logic             ovl,
   input  logic             otp,
   input  logic             vlow,
   output logic [3:0]       vsel,
   output logic             tone_en,
   output logic             tone_ext,
   output logic             plim_off,
   output logic             ovl_hold,
   output logic             thm_hold
);
   localparam logic [PTR_W-1:0] FLAG_PTR = PTR_W'(FLAG_REG);
   localparam int unsigned      CTRL_END = CTRL_BASE + NUM_CTRL;

   logic [NUM_CTRL-1:0][7:0] ctrl;
   logic                     wr_ctrl;

   assign wr_ctrl = wr_en && (int'(wr_addr) >= CTRL_BASE) && (int'(wr_addr) < CTRL_END);

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      localparam logic [PTR_W-1:0] MY_ADDR = PTR_W'(CTRL_BASE + i);
      if (i == 0) begin : g_vsel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ctrl[i] <= '0;
            else if (uv)
               ctrl[i] <= '0;
            else begin
               if (wr_en && wr_addr == MY_ADDR)
                  ctrl[i] <= vsel_clr ? {wr_data[7:4], 4'h0} : wr_data;
               else if (vsel_clr)
                  ctrl[i][3:0] <= 4'h0;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ctrl[i] <= '0;
            else if (uv)
               ctrl[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
               ctrl[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = 8'h00;
      if (rd_addr == FLAG_PTR)
         rd_data = flag_byte(ovl, otp, vlow);
      for (int k = 0; k < NUM_CTRL; k++)
         if (int'(rd_addr) == CTRL_BASE + k)
            rd_data = ctrl[k];
   end

   assign vsel     = ctrl[0][3:0];
   assign tone_en  = ctrl[1][0];
   assign tone_ext = ctrl[1][2];
   assign plim_off = ctrl[2][2];
   assign ovl_hold = ctrl[3][3];
   assign thm_hold = ctrl[3][6];

   AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      uv |=> (ctrl == '0));  // R8
   AST_VSEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (vsel_clr && !uv) |=> (ctrl[0][3:0] == 4'h0));  // R11
   AST_RO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ctrl && !vsel_clr && !uv) |=> $stable(ctrl));  // R7
endmodule

// File: rtl/psc_i2c_regs.sv
module psc_i2c_regs #(
   parameter logic [6:0]  DEV_BASE    = 7'b0001000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PTR_W       = 8,
   parameter int unsigned CTRL_BASE   = 2,
   parameter int unsigned NUM_CTRL    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uv_i,
   input  logic       addr_sel_i,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic       ovl_flag_i,
   input  logic       otp_flag_i,
   input  logic       vlow_flag_i,
   input  logic       vsel_clr_i,
   output logic [3:0] vsel_o,
   output logic       tone_en_o,
   output logic       tone_ext_o,
   output logic       plim_off_o,
   output logic       ovl_hold_o,
   output logic       thm_hold_o,
   output logic       stat_rd_o
);
   localparam int unsigned FLAG_REG = 0;

   initial begin
      AST_SYNC_DEPTH: assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      AST_MAP_FITS: assert (CTRL_BASE + NUM_CTRL <= (1 << PTR_W) && NUM_CTRL >= 4)
         else $error("control map does not fit pointer or lacks field bytes");
      AST_DEV_EVEN: assert (DEV_BASE[0] == 1'b0)
         else $error("DEV_BASE LSB is taken by the strap");
   end

   logic             scl_s, scl_rise, scl_fall;
   logic             sda_s, sda_rise, sda_fall;
   logic [7:0]       rd_data;
   logic [PTR_W-1:0] ptr;
   logic             wr_en;
   logic [PTR_W-1:0] wr_addr;
   logic [7:0]       wr_data;

   psc_line_sync #(.STAGES(SYNC_STAGES), .IDLE_HI(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   psc_line_sync #(.STAGES(SYNC_STAGES), .IDLE_HI(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   psc_bus_engine #(.DEV_BASE(DEV_BASE), .PTR_W(PTR_W), .FLAG_REG(FLAG_REG)) u_engine (
      .clk(clk), .rst_n(rst_n), .uv(uv_i), .strap(addr_sel_i),
      .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sda_oe(sda_pull_o), .stat_pulse(stat_rd_o)
   );

   psc_regbank #(.PTR_W(PTR_W), .CTRL_BASE(CTRL_BASE), .NUM_CTRL(NUM_CTRL),
                 .FLAG_REG(FLAG_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .uv(uv_i), .vsel_clr(vsel_clr_i),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(ptr), .rd_data(rd_data),
      .ovl(ovl_flag_i), .otp(otp_flag_i), .vlow(vlow_flag_i),
      .vsel(vsel_o), .tone_en(tone_en_o), .tone_ext(tone_ext_o),
      .plim_off(plim_off_o), .ovl_hold(ovl_hold_o), .thm_hold(thm_hold_o)
   );
endmodule

// File: tb/sim_psc_i2c_regs.sv
`timescale 1ns/1ps
module sim_psc_i2c_regs;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv = 1'b0, strap = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_pull;
   logic sda_line;
   logic ovl = 1'b0, otp = 1'b0, vlow = 1'b0, vclr = 1'b0;
   logic [3:0] vsel;
   logic tone_en, tone_ext, plim_off, ovl_hold, thm_hold, stat_rd;

   int tests = 0, fails = 0;
   bit chk_en = 1'b0;
   bit done = 1'b0;
   logic [7:0] ref_regs [4];
   int strobe_cnt = 0, strobe_run = 0, strobe_max = 0;

   always #4 clk = ~clk;
   assign sda_line = sda_m & ~sda_pull;

   psc_i2c_regs u0 (
      .clk(clk), .rst_n(rst_n), .uv_i(uv), .addr_sel_i(strap),
      .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
      .ovl_flag_i(ovl), .otp_flag_i(otp), .vlow_flag_i(vlow), .vsel_clr_i(vclr),
      .vsel_o(vsel), .tone_en_o(tone_en), .tone_ext_o(tone_ext),
      .plim_off_o(plim_off), .ovl_hold_o(ovl_hold), .thm_hold_o(thm_hold),
      .stat_rd_o(stat_rd)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int p);
      if (p == 0) return {vlow, otp, 5'b0, ovl};
      if (p >= 2 && p <= 5) return ref_regs[p-2];
      return 8'h00;
   endfunction

   function automatic logic [6:0] dev();
      return {6'b000100, strap};
   endfunction

   // every-clock comparison of field outputs against the reference map (R6)
   always @(negedge clk) begin
      if (chk_en) begin
         logic [8:0] act, exp;
         act = {vsel, tone_en, tone_ext, plim_off, ovl_hold, thm_hold};
         exp = {ref_regs[0][3:0], ref_regs[1][0], ref_regs[1][2], ref_regs[2][2],
                ref_regs[3][3], ref_regs[3][6]};
         chk(act == exp, "R6 fields", int'(act), int'(exp));
      end
   end

   always @(posedge clk) begin
      if (stat_rd) begin
         if (strobe_run == 0) strobe_cnt++;
         strobe_run++;
         if (strobe_run > strobe_max) strobe_max = strobe_run;
      end else begin
         strobe_run = 0;
      end
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      chk_en = 1'b0;
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(Q + 8);
      if (!uv) chk_en = 1'b1;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(Q);
         scl_m = 1'b1; wq(2*Q);
         scl_m = 1'b0; wq(Q);
      end
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      ack = ~sda_line;
      wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(Q);
         scl_m = 1'b1; wq(Q);
         b[i] = sda_line;
         wq(Q);
         scl_m = 1'b0; wq(Q);
      end
      sda_m = ~give_ack; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
      sda_m = 1'b1;
   endtask

   task automatic do_write(input int p, input logic [7:0] d[$]);
      bit a;
      int ptr = p;
      i2c_start();
      send_byte({dev(), 1'b0}, a); chk(a, "R1 write address ack", a, 1);
      send_byte(8'(p), a);         chk(a, "R4 pointer ack", a, 1);
      foreach (d[i]) begin
         send_byte(d[i], a);       chk(a, "R2 data ack", a, 1);
         if (ptr >= 2 && ptr <= 5) ref_regs[ptr-2] = d[i];
         ptr++;
      end
      i2c_stop();
   endtask

   task automatic do_read(input int p, input int n, input string req);
      bit a;
      logic [7:0] b;
      i2c_start();
      send_byte({dev(), 1'b0}, a); chk(a, "R1 address ack", a, 1);
      send_byte(8'(p), a);         chk(a, "R4 pointer ack", a, 1);
      i2c_stop();
      i2c_start();
      send_byte({dev(), 1'b1}, a); chk(a, "R3 read address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n-1, b);
         chk(b == exp_rd(p+i), req, b, exp_rd(p+i));
      end
      i2c_stop();
   endtask

   initial begin
      bit a;
      int sc;
      foreach (ref_regs[i]) ref_regs[i] = 8'h00;
      wq(5);
      rst_n = 1'b1;
      wq(5);
      // R9 reset state
      chk({vsel, tone_en, tone_ext, plim_off, ovl_hold, thm_hold, stat_rd, sda_pull} == 0,
          "R9 reset outputs", {vsel, tone_en, tone_ext, plim_off, ovl_hold, thm_hold}, 0);
      chk_en = 1'b1;
      do_read(2, 4, "R9 reset registers");

      // R2 burst write with auto-increment, R3/R6 burst readback
      do_write(2, '{8'hA5, 8'h3C, 8'h04, 8'h08});
      chk(vsel == 4'h5 && tone_ext && !tone_en && plim_off && ovl_hold && !thm_hold,
          "R6 field decode", {vsel, tone_en, tone_ext, plim_off, ovl_hold, thm_hold}, 9'h0AE);
      do_read(2, 4, "R3 burst readback");
      do_write(4, '{8'hFB, 8'h41});
      do_read(3, 3, "R2 pointer mid-map");

      // R1 wrong address with strap low, then strap high
      i2c_start();
      send_byte({7'b0001001, 1'b0}, a); chk(!a, "R1 foreign address nack", a, 0);
      i2c_stop();
      strap = 1'b1;
      i2c_start();
      send_byte({7'b0001000, 1'b0}, a); chk(!a, "R1 strap-high rejects 0x08", a, 0);
      i2c_stop();
      do_read(5, 1, "R1 strap-high read");
      strap = 1'b0;

      // R7 discarded writes and reads beyond the map
      do_write(0, '{8'hFF, 8'hFF});
      do_write(6, '{8'h77, 8'h66});
      do_read(2, 6, "R7 map unchanged and 0x6+ reads zero");

      // R5 status bytes, R10 strobe
      ovl = 1'b1; vlow = 1'b1;
      strobe_cnt = 0; strobe_max = 0;
      do_read(0, 2, "R5 status bytes");
      chk(strobe_cnt == 1, "R10 strobe count", strobe_cnt, 1);
      chk(strobe_max == 1, "R10 strobe width", strobe_max, 1);
      ovl = 1'b0; otp = 1'b1;
      do_read(0, 1, "R5 over-temperature bit");
      sc = strobe_cnt;
      do_read(2, 2, "R3 read without strobe");
      chk(strobe_cnt == sc, "R10 no strobe off flag byte", strobe_cnt, sc);

      // R11 voltage-select clear
      do_write(2, '{8'hA7});
      chk_en = 1'b0;
      vclr = 1'b1; wq(1); vclr = 1'b0;
      ref_regs[0] = ref_regs[0] & 8'hF0;
      wq(2); chk_en = 1'b1;
      chk(vsel == 4'h0, "R11 vsel cleared", vsel, 0);
      do_read(2, 1, "R11 upper bits kept");

      // R8 undervoltage
      chk_en = 1'b0;
      uv = 1'b1; wq(3);
      foreach (ref_regs[i]) ref_regs[i] = 8'h00;
      chk({vsel, tone_en, tone_ext, plim_off, ovl_hold, thm_hold} == 0,
          "R8 controls zero in undervoltage",
          {vsel, tone_en, tone_ext, plim_off, ovl_hold, thm_hold}, 0);
      i2c_start();
      send_byte({dev(), 1'b0}, a); chk(!a, "R8 no ack in undervoltage", a, 0);
      send_byte(8'h02, a);         chk(!a, "R8 no ack on data", a, 0);
      i2c_stop();
      uv = 1'b0; wq(3); chk_en = 1'b1;
      do_read(2, 4, "R8 registers zero after undervoltage");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule